// File: doc/BRIEF.md
# Dual-Flash Boot Failover Controller

This block supervises the start-up of a host processor that fetches its firmware from one of two serial flash devices. The two devices share the serial clock and both data lines. The block decides which device's active-low chip-select may follow the host's chip-select, and it forces the other one high. It drives the host's boot-mode strap pins to the serial-flash setting. It holds the host in reset for a fixed pulse, then releases it and starts a watchdog window.

If the host does not signal a good boot on its success input before the window ends, the attempt counts as failed. The block then steers to the other device, pulses reset again and retries. Devices alternate on every failure. When every device has used up its attempt budget, the block raises a failure status and keeps the host in reset.

A good boot locks the selection and stops the watchdog. A re-arm input then restarts supervision from the primary device. Routing changes only while the host's chip-select is idle, so a transfer that is in progress is never cut.

Top module: `boot_failover`

## Requirements
- R1: While rst_ni is low and right after it: host_rst_n_o is 0, active_dev_o is 0 (primary), retry_cnt_o is 0, locked_o and boot_fail_o are 0, and boot_mode_o equals BOOT_MODE_SPI (default 3'b011).
- R2: Each boot attempt holds host_rst_n_o low for exactly RST_CYCLES clock cycles, provided the chip-select routing already matches the target device.
- R3: Without a boot-success indication, host_rst_n_o stays high for exactly TIMEOUT_CYCLES cycles. The attempt then counts as failed and reset is asserted again.
- R4: Each failed attempt increments retry_cnt_o by one and switches active_dev_o to the other device (0 to 1, 1 to 0).
- R5: boot_ok_i passes through two synchronizer flops. If it is high from cycle index TIMEOUT_CYCLES-3 or earlier of the release window (index 0 being the first cycle with reset high), locked_o rises within 3 cycles. If it rises only at index TIMEOUT_CYCLES-2, the attempt still fails.
- R6: While locked, no timeout occurs, host_rst_n_o stays high, the device selection stays fixed and boot_mode_o equals BOOT_MODE_RUN (default 3'b000).
- R7: Outside the failure state, flash_cs_n_o[active_dev_o] equals host_cs_n_i and the other chip-select is 1.
- R8: active_dev_o changes only on a clock edge at which host_cs_n_i is high. Host reset is not released until active_dev_o equals the target device, so the reset pulse stretches while the host chip-select stays low.
- R9: After 2*MAX_TRIES failed attempts, boot_fail_o is 1, host_rst_n_o stays 0, both flash_cs_n_o bits are 1 whatever host_cs_n_i does, and retry_cnt_o equals 2*MAX_TRIES.
- R10: A rearm_i pulse in the locked or failure state restarts supervision: device 0, retry count 0, a new reset pulse. rearm_i has no effect during the reset pulse or the watchdog window.
- R11: boot_ok_i is ignored while the host is held in reset, both during a reset pulse and in the failure state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| rearm_i | input | 1 | Restart supervision from the locked or failure state |
| boot_ok_i | input | 1 | Asynchronous boot-success level from the host |
| host_cs_n_i | input | 1 | Host serial chip-select, active low |
| flash_cs_n_o | output | 2 | Chip-selects of flash device 1 and 0, active low |
| host_rst_n_o | output | 1 | Host reset, active low |
| boot_mode_o | output | MODE_W | Host boot-mode strap pins |
| active_dev_o | output | 1 | Index of the device currently routed |
| retry_cnt_o | output | RETRY_W | Failed attempts since power-on or re-arm |
| locked_o | output | 1 | Host booted, selection locked |
| boot_fail_o | output | 1 | Every attempt failed, host held in reset |

## Verification
A wrong state or counter inside this block shows at the ports within one attempt. A miscounted pulse or window changes the measured low and high lengths of host_rst_n_o by cycles. A wrong target shows in active_dev_o and in which flash_cs_n_o bit follows the host chip-select one cycle after the failure. A wrong synchronizer depth or priority moves the lock boundary, so the late boot-success case at window index TIMEOUT_CYCLES-2 would lock instead of failing. A routing register that ignores the idle condition moves active_dev_o while the host chip-select is still low, on the first edge after a re-arm.

// File: rtl/bfo_pkg.sv
package bfo_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,  // host in reset, pulse running
    ST_WAIT = 2'd1,  // host released, watchdog running
    ST_LOCK = 2'd2,  // boot confirmed
    ST_FAIL = 2'd3   // attempts exhausted
  } bfo_state_e;
endpackage

// File: rtl/bfo_sync.sv
module bfo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/bfo_steer.sv
module bfo_steer #(
  parameter int N_DEV = 2,
  localparam int SEL_W = $clog2(N_DEV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] tgt_i,
  input  logic             host_cs_n_i,
  input  logic             block_i,
  output logic [N_DEV-1:0] flash_cs_n_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  // routing follows the target only while the bus is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sel_q <= '0;
    else if (host_cs_n_i) sel_q <= tgt_i;
  end

  for (genvar d = 0; d < N_DEV; d++) begin : g_cs
    assign flash_cs_n_o[d] = block_i | (sel_q != SEL_W'(d)) | host_cs_n_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/bfo_fsm.sv
module bfo_fsm
  import bfo_pkg::*;
#(
  parameter int RST_CYCLES     = 64,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int MAX_TRIES      = 2,
  localparam int TOTAL   = 2 * MAX_TRIES,
  localparam int RETRY_W = $clog2(TOTAL + 1),
  localparam int CNT_MAX = (RST_CYCLES > TIMEOUT_CYCLES) ? RST_CYCLES : TIMEOUT_CYCLES,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ok_i,
  input  logic               rearm_i,
  input  logic               sel_ok_i,
  output bfo_state_e         state_o,
  output logic               tgt_o,
  output logic [RETRY_W-1:0] retry_o
);
  localparam logic [CNT_W-1:0]   RST_LAST = CNT_W'(RST_CYCLES - 1);
  localparam logic [CNT_W-1:0]   TO_LAST  = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [RETRY_W-1:0] RET_LAST = RETRY_W'(TOTAL - 1);

  bfo_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tgt_q;
  logic [RETRY_W-1:0] retry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      tgt_q   <= 1'b0;
      retry_q <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (cnt_q == RST_LAST) begin
            if (sel_ok_i) begin
              state_q <= ST_WAIT;
              cnt_q   <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ok_i) begin
            state_q <= ST_LOCK;
            cnt_q   <= '0;
          end else if (cnt_q == TO_LAST) begin
            cnt_q   <= '0;
            retry_q <= retry_q + 1'b1;
            if (retry_q == RET_LAST) begin
              state_q <= ST_FAIL;
            end else begin
              state_q <= ST_HOLD;
              tgt_q   <= ~tgt_q;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOCK, ST_FAIL: begin
          if (rearm_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            tgt_q   <= 1'b0;
            retry_q <= '0;
          end
        end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign state_o = state_q;
  assign tgt_o   = tgt_q;
  assign retry_o = retry_q;
endmodule

// File: rtl/boot_failover.sv
module boot_failover
  import bfo_pkg::*;
#(
  parameter int RST_CYCLES     = 64,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int MAX_TRIES      = 2,
  parameter int MODE_W         = 3,
  parameter logic [MODE_W-1:0] BOOT_MODE_SPI = 3'b011,
  parameter logic [MODE_W-1:0] BOOT_MODE_RUN = 3'b000,
  localparam int RETRY_W = $clog2(2 * MAX_TRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rearm_i,
  input  logic               boot_ok_i,
  input  logic               host_cs_n_i,
  output logic [1:0]         flash_cs_n_o,
  output logic               host_rst_n_o,
  output logic [MODE_W-1:0]  boot_mode_o,
  output logic               active_dev_o,
  output logic [RETRY_W-1:0] retry_cnt_o,
  output logic               locked_o,
  output logic               boot_fail_o
);
  bfo_state_e state;
  logic       ok_sync;
  logic       tgt_dev;
  logic       sel;

  bfo_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (boot_ok_i),
    .q_o    (ok_sync)
  );

  bfo_fsm #(
    .RST_CYCLES     (RST_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .MAX_TRIES      (MAX_TRIES)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ok_i     (ok_sync),
    .rearm_i  (rearm_i),
    .sel_ok_i (sel == tgt_dev),
    .state_o  (state),
    .tgt_o    (tgt_dev),
    .retry_o  (retry_cnt_o)
  );

  bfo_steer #(.N_DEV(2)) u_steer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgt_i        (tgt_dev),
    .host_cs_n_i  (host_cs_n_i),
    .block_i      (state == ST_FAIL),
    .flash_cs_n_o (flash_cs_n_o),
    .sel_o        (sel)
  );

  assign host_rst_n_o = (state == ST_WAIT) || (state == ST_LOCK);
  assign boot_mode_o  = (state == ST_LOCK) ? BOOT_MODE_RUN : BOOT_MODE_SPI;
  assign active_dev_o = sel;
  assign locked_o     = (state == ST_LOCK);
  assign boot_fail_o  = (state == ST_FAIL);
endmodule

// File: rtl/boot_failover_chk.sv
module boot_failover_chk #(
  parameter int RST_CYCLES     = 64,
  parameter int MAX_TRIES      = 2,
  parameter int MODE_W         = 3,
  parameter logic [MODE_W-1:0] BOOT_MODE_SPI = 3'b011,
  localparam int RETRY_W = $clog2(2 * MAX_TRIES + 1),
  localparam int LO_W    = $clog2(RST_CYCLES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rearm_i,
  input logic               host_cs_n_i,
  input logic [1:0]         flash_cs_n_o,
  input logic               host_rst_n_o,
  input logic [MODE_W-1:0]  boot_mode_o,
  input logic               active_dev_o,
  input logic [RETRY_W-1:0] retry_cnt_o,
  input logic               locked_o,
  input logic               boot_fail_o,
  input logic               tgt_dev
);
  logic [LO_W-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 lo_cnt <= '0;
    else if (host_rst_n_o)                       lo_cnt <= '0;
    else if (lo_cnt != LO_W'(RST_CYCLES))        lo_cnt <= lo_cnt + 1'b1;
  end

  assert_min_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rst_n_o) |-> lo_cnt == LO_W'(RST_CYCLES));

  assert_one_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_cs_n_o[0] && !flash_cs_n_o[1]));

  assert_mode_in_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rst_n_o |-> boot_mode_o == BOOT_MODE_SPI);

  assert_mode_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rst_n_o) |-> $stable(boot_mode_o));

  assert_sel_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_dev_o != $past(active_dev_o)) |-> $past(host_cs_n_i));

  assert_release_on_tgt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rst_n_o) |-> active_dev_o == tgt_dev);

  assert_fail_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_fail_o |-> (!host_rst_n_o && flash_cs_n_o == 2'b11 &&
                     retry_cnt_o == RETRY_W'(2 * MAX_TRIES)));

  assert_fail_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_fail_o && !rearm_i) |=> boot_fail_o);

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !rearm_i) |=> (locked_o && host_rst_n_o));

  assert_retry_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o <= RETRY_W'(2 * MAX_TRIES));
endmodule

bind boot_failover boot_failover_chk #(
  .RST_CYCLES    (RST_CYCLES),
  .MAX_TRIES     (MAX_TRIES),
  .MODE_W        (MODE_W),
  .BOOT_MODE_SPI (BOOT_MODE_SPI)
) u_chk (.*);

// File: tb/sim_boot_failover.sv
module sim_boot_failover;
  localparam int RST = 4;
  localparam int TO  = 20;
  localparam int MAXT = 2;
  localparam int TOTAL = 2 * MAXT;
  localparam logic [2:0] M_SPI = 3'b011;
  localparam logic [2:0] M_RUN = 3'b000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rearm_i = 1'b0;
  logic       boot_ok_i = 1'b0;
  logic       host_cs_n_i = 1'b1;
  logic [1:0] flash_cs_n_o;
  logic       host_rst_n_o;
  logic [2:0] boot_mode_o;
  logic       active_dev_o;
  logic [2:0] retry_cnt_o;
  logic       locked_o;
  logic       boot_fail_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  boot_failover #(
    .RST_CYCLES(RST), .TIMEOUT_CYCLES(TO), .MAX_TRIES(MAXT), .MODE_W(3),
    .BOOT_MODE_SPI(M_SPI), .BOOT_MODE_RUN(M_RUN)
  ) u0 (.*);

  function automatic logic [1:0] exp_cs(input logic dev, input logic fail, input logic hcs);
    logic [1:0] r;
    r = 2'b11;
    if (!fail) r[dev] = hcs;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas_low(output int n);
    n = 0;
    while (host_rst_n_o == 1'b0 && n < 1000) begin n++; @(negedge clk_i); end
  endtask

  task automatic meas_high(output int n);
    n = 0;
    while (host_rst_n_o == 1'b1 && n < 1000) begin n++; @(negedge clk_i); end
  endtask

  task automatic do_rearm();
    host_cs_n_i = 1'b1;
    boot_ok_i   = 1'b0;
    rearm_i     = 1'b1;
    @(negedge clk_i);
    rearm_i = 1'b0;
  endtask

  // starts at first low sample of attempt 0; k_ok==TOTAL means never boots
  task automatic run_round(input int k_ok, input int off);
    int n;
    for (int a = 0; a < TOTAL; a++) begin
      meas_low(n);
      chk("R2 reset pulse length", n, RST);
      chk("R4 device per attempt", active_dev_o, a % 2);
      chk("R4 retry count", retry_cnt_o, a);
      if (a == k_ok) begin
        repeat (off) @(negedge clk_i);
        boot_ok_i = 1'b1;
        repeat (4) @(negedge clk_i);
        chk("R5 locked after boot ok", locked_o, 1);
        chk("R6 run boot mode", boot_mode_o, M_RUN);
        n = 0;
        for (int c = 0; c < 3 * TO; c++) begin
          host_cs_n_i = 1'($urandom_range(0, 1));
          #1;
          chk("R7 cs steering", flash_cs_n_o, exp_cs(1'(a % 2), 1'b0, host_cs_n_i));
          if (!host_rst_n_o || !locked_o) n++;
          @(negedge clk_i);
        end
        host_cs_n_i = 1'b1;
        chk("R6 no timeout while locked", n, 0);
        chk("R6 device held", active_dev_o, a % 2);
        return;
      end
      meas_high(n);
      chk("R3 watchdog window", n, TO);
    end
    chk("R9 boot fail", boot_fail_o, 1);
    chk("R9 retry total", retry_cnt_o, TOTAL);
    host_cs_n_i = 1'b0;
    #1;
    chk("R9 both cs high", flash_cs_n_o, 2'b11);
    @(negedge clk_i);
    chk("R9 host in reset", host_rst_n_o, 0);
    host_cs_n_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd5813));
    repeat (5) @(negedge clk_i);
    chk("R1 host reset low", host_rst_n_o, 0);
    chk("R1 primary device", active_dev_o, 0);
    chk("R1 retry zero", retry_cnt_o, 0);
    chk("R1 not locked", locked_o, 0);
    chk("R1 no fail", boot_fail_o, 0);
    chk("R1 spi boot mode", boot_mode_o, M_SPI);
    chk("R1 cs idle", flash_cs_n_o, 2'b11);
    rst_ni = 1'b1;

    // boundary: boot ok at last accepted window index, second device
    run_round(1, TO - 3);

    // R8: re-arm while host chip-select is busy
    host_cs_n_i = 1'b0;
    rearm_i = 1'b1;
    @(negedge clk_i);
    rearm_i = 1'b0;
    boot_ok_i = 1'b0;
    for (int c = 0; c < 8; c++) begin
      chk("R8 routing held while cs low", active_dev_o, 1);
      chk("R8 cs stays on old device", flash_cs_n_o, 2'b01);
      chk("R8 reset stretched", host_rst_n_o, 0);
      @(negedge clk_i);
    end
    host_cs_n_i = 1'b1;
    @(negedge clk_i);
    chk("R8 routing updates when idle", active_dev_o, 0);
    meas_low(n);
    chk("R10 retry cleared", retry_cnt_o, 0);
    chk("R10 restart on primary", active_dev_o, 0);
    boot_ok_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R5 locked on primary", locked_o, 1);

    // R5/R11: boot ok one cycle too late
    do_rearm();
    meas_low(n);
    chk("R2 reset pulse length", n, RST);
    repeat (TO - 2) @(negedge clk_i);
    boot_ok_i = 1'b1;
    meas_high(n);
    chk("R5 late boot ok still fails", n + TO - 2, TO);
    boot_ok_i = 1'b0;
    meas_low(n);
    chk("R11 ok ignored in reset pulse", n, RST);
    chk("R11 not locked", locked_o, 0);
    chk("R4 switched device", active_dev_o, 1);
    chk("R4 retry one", retry_cnt_o, 1);
    boot_ok_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R5 locked after retry", locked_o, 1);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      do_rearm();
      run_round(int'($urandom_range(0, TOTAL)), int'($urandom_range(0, TO - 3)));
    end

    // R10: re-arm inside watchdog window is ignored, then run to failure
    do_rearm();
    meas_low(n);
    n = 0;
    while (host_rst_n_o && n < 1000) begin
      rearm_i = (n == 5);
      n++;
      @(negedge clk_i);
    end
    rearm_i = 1'b0;
    chk("R10 rearm ignored in window", n, TO);
    chk("R10 retry after ignored rearm", retry_cnt_o, 1);
    for (int a = 1; a < TOTAL; a++) begin
      meas_low(n);
      meas_high(n);
    end
    chk("R9 failure reached", boot_fail_o, 1);
    boot_ok_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R11 ok ignored in failure", boot_fail_o, 1);
    chk("R11 host kept in reset", host_rst_n_o, 0);
    chk("R11 not locked in failure", locked_o, 0);
    do_rearm();
    chk("R10 failure cleared", boot_fail_o, 0);
    meas_low(n);
    chk("R10 pulse after rearm", n, RST);
    chk("R10 retry cleared from failure", retry_cnt_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule